// File: doc/BRIEF.md
# SPI Register Bit-Field Modifier

This block is a serial command target that changes selected bits of a small on-chip bank of 8-bit control registers. A host lowers chip-select, clocks in a one-byte header (a 3-bit command code and a 5-bit register index), then one or more 8-bit mask bytes. A set command merges the mask into the chosen register with OR. A clear command removes the masked bits from it with AND-NOT. The bank has a combinational read port so that its contents can be observed during test.

The serial pins are brought into the system clock domain through two-flop synchronizers and SCK rising edges are found there, so the system clock has to run at least four times as fast as SCK. The serial link has no flow control: the block never stalls the host, and each completed mask byte is applied in a single system clock cycle, so there is no back-pressure to manage. A per-register protect vector marks registers belonging to a guarded class, which no command may change.

Top module: `spi_bitmod`

## Requirements
- R1: After reset every register of the bank reads 00h.
- R2: Bits are sampled on SCK rising edges while chip-select is low (SPI mode 0). After chip-select falls, the first 3 bits are the command code, the next 5 bits are the register index sent from bit 4 down to bit 0, and every following group of 8 bits is a mask byte sent bit 7 first.
- R3: Command code 100b (set) makes the register equal to its old value ORed with the mask.
- R4: Command code 101b (clear) makes the register equal to its old value ANDed with the inverted mask; F1h cleared with mask 17h gives E0h.
- R5: The update takes effect on the SCK rising edge that samples the last mask bit and is visible on the read port no later than 3 system clock cycles after that edge, while chip-select is still low.
- R6: When chip-select rises before all 8 bits of a mask byte have arrived, that partial byte is dropped and the register keeps its value.
- R7: A register whose bit in the protect vector is 1 is never changed by set or clear.
- R8: Any command code other than 100b or 101b leaves every register unchanged until chip-select rises; the next transaction is decoded normally.
- R9: Further mask bytes within one transaction each apply the same command to the same register, in the order received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x SCK |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Active-low chip-select |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_mosi | input | 1 | Serial data into the block |
| protect_mask | input | 32 | Bit i high marks register i as write-protected |
| rd_addr | input | 5 | Read port register index |
| rd_data | output | 8 | Contents of the register at rd_addr (combinational) |

## Verification
Each result is due three system clock cycles after the SCK rising edge that carries its last mask bit: two synchronizer stages and one register write. The bench drives SCK with a half period of four system clocks and only reads back a register after the SCK falling edge that follows the final bit, well beyond that latency yet before chip-select rises, which also shows the update does not wait for the end of the transaction. For dropped bytes, protected registers and unknown codes, the expected unchanged value is read back through the read port after chip-select has risen and the synchronizer has settled.

// File: rtl/spi_bitmod_pkg.sv
package spi_bitmod_pkg;
  localparam int OPC_W = 3;
  localparam logic [OPC_W-1:0] OPC_SET = 3'b100;
  localparam logic [OPC_W-1:0] OPC_CLR = 3'b101;

  typedef enum logic [1:0] {
    ST_HDR  = 2'd0,
    ST_DATA = 2'd1,
    ST_SKIP = 2'd2
  } cmd_state_e;
endpackage

// File: rtl/spi_bitmod_sync.sv
module spi_bitmod_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= RST_VAL;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_bitmod_cmd.sv
module spi_bitmod_cmd
  import spi_bitmod_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              sck_s,
  input  logic              mosi_s,
  output logic              sck_rise,
  output logic              wr_en,
  output logic              wr_set,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_mask
);
  localparam int HDR_W = OPC_W + ADDR_W;
  localparam int SH_W  = (HDR_W > DATA_W) ? HDR_W : DATA_W;
  localparam int CNT_W = $clog2(SH_W + 1);
  localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  cmd_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [SH_W-1:0]   shreg;
  logic              sck_d;
  logic              is_set;
  logic [ADDR_W-1:0] addr_q;
  logic [SH_W-1:0]   next_sh;
  logic [OPC_W-1:0]  opc;

  assign sck_rise = sck_s & ~sck_d;
  assign next_sh  = {shreg[SH_W-2:0], mosi_s};
  assign opc      = next_sh[HDR_W-1 -: OPC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d  <= 1'b0;
      state  <= ST_HDR;
      cnt    <= '0;
      shreg  <= '0;
      is_set <= 1'b0;
      addr_q <= '0;
    end else begin
      sck_d <= sck_s;
      if (cs_s) begin
        state <= ST_HDR;
        cnt   <= '0;
      end else if (sck_rise) begin
        shreg <= next_sh;
        case (state)
          ST_HDR: begin
            if (cnt == HDR_LAST) begin
              cnt    <= '0;
              addr_q <= next_sh[ADDR_W-1:0];
              is_set <= (opc == OPC_SET);
              state  <= (opc == OPC_SET || opc == OPC_CLR) ? ST_DATA : ST_SKIP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DATA: begin
            if (cnt == DATA_LAST) cnt <= '0;
            else                  cnt <= cnt + 1'b1;
          end
          default: cnt <= '0;
        endcase
      end
    end
  end

  assign wr_en   = (state == ST_DATA) && sck_rise && !cs_s && (cnt == DATA_LAST);
  assign wr_set  = is_set;
  assign wr_addr = addr_q;
  assign wr_mask = next_sh[DATA_W-1:0];
endmodule

// File: rtl/spi_bitmod_regs.sv
module spi_bitmod_regs #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_set,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_mask,
  input  logic [(1<<ADDR_W)-1:0] protect,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] bank [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic hit;
    assign hit = wr_en && (wr_addr == ADDR_W'(i)) && !protect[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bank[i] <= '0;
      else if (hit)    bank[i] <= wr_set ? (bank[i] | wr_mask) : (bank[i] & ~wr_mask);
    end
  end

  assign rd_data = bank[rd_addr];
endmodule

// File: rtl/spi_bitmod.sv
module spi_bitmod #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   spi_cs_n,
  input  logic                   spi_sck,
  input  logic                   spi_mosi,
  input  logic [(1<<ADDR_W)-1:0] protect_mask,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [DATA_W-1:0]      rd_data
);
  logic [2:0]        pins_s;
  logic              cs_s;
  logic              sck_s;
  logic              mosi_s;
  logic              sck_rise;
  logic              wr_en;
  logic              wr_set;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_mask;

  spi_bitmod_sync #(
    .W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)
  ) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_cs_n, spi_sck, spi_mosi}),
    .q(pins_s)
  );

  assign cs_s   = pins_s[2];
  assign sck_s  = pins_s[1];
  assign mosi_s = pins_s[0];

  spi_bitmod_cmd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmd (
    .clk(clk), .rst_n(rst_n),
    .cs_s(cs_s), .sck_s(sck_s), .mosi_s(mosi_s),
    .sck_rise(sck_rise),
    .wr_en(wr_en), .wr_set(wr_set), .wr_addr(wr_addr), .wr_mask(wr_mask)
  );

  spi_bitmod_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_set(wr_set), .wr_addr(wr_addr), .wr_mask(wr_mask),
    .protect(protect_mask),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: rtl/spi_bitmod_chk.sv
module spi_bitmod_chk #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_en,
  input logic                   wr_set,
  input logic [ADDR_W-1:0]      wr_addr,
  input logic [DATA_W-1:0]      wr_mask,
  input logic [(1<<ADDR_W)-1:0] protect,
  input logic [ADDR_W-1:0]      rd_addr,
  input logic [DATA_W-1:0]      rd_data
);
  logic tgt_open;
  logic tgt_seen;
  assign tgt_seen = wr_en && (wr_addr == rd_addr);
  assign tgt_open = tgt_seen && !protect[wr_addr];

  // R3: set merges the mask into the watched register
  assert_set_or_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_open && wr_set) |=> (rd_addr != $past(rd_addr)) ||
                             (rd_data == ($past(rd_data) | $past(wr_mask))));

  // R4: clear removes the masked bits
  assert_clear_andnot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_open && !wr_set) |=> (rd_addr != $past(rd_addr)) ||
                              (rd_data == ($past(rd_data) & ~$past(wr_mask))));

  // R7: protected register keeps its value through a write strobe
  assert_protect_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_seen && protect[wr_addr]) |=> (rd_addr != $past(rd_addr)) || $stable(rd_data));

  // R8: without a write strobe nothing in the bank moves
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (rd_addr != $past(rd_addr)) || $stable(rd_data));
endmodule

bind spi_bitmod spi_bitmod_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .wr_en(wr_en), .wr_set(wr_set), .wr_addr(wr_addr), .wr_mask(wr_mask),
  .protect(protect_mask), .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/spi_bitmod_tb.sv
module spi_bitmod_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SCK_HALF   = 4 * CLK_PERIOD;
  localparam logic [2:0] SET = 3'b100;
  localparam logic [2:0] CLR = 3'b101;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sck = 1'b0;
  logic        mosi = 1'b0;
  logic [31:0] protect_mask = 32'h8000_0001;
  logic [4:0]  rd_addr = '0;
  logic [7:0]  rd_data;

  typedef struct {
    logic [4:0] addr;
    logic [7:0] exp;
    string      req;
  } item_t;

  item_t      sb_q[$];
  logic [7:0] model [32];
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_bitmod u_dut (
    .clk(clk), .rst_n(rst_n),
    .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
    .protect_mask(protect_mask),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic expect_reg(input logic [4:0] a, input string req);
    item_t it;
    it.addr = a; it.exp = model[a]; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic drain();
    wait (sb_q.size() == 0);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      mosi = v[i];
      #SCK_HALF; sck = 1'b1;
      #SCK_HALF; sck = 1'b0;
    end
  endtask

  task automatic cs_begin();
    @(negedge clk);
    cs_n = 1'b0;
    #SCK_HALF;
  endtask

  task automatic cs_end();
    #SCK_HALF;
    cs_n = 1'b1;
    #(SCK_HALF * 2);
  endtask

  // Full transaction; each mask byte is checked before chip-select rises (R5)
  task automatic bitmod(input logic [2:0] opc, input logic [4:0] a,
                        input logic [7:0] m0, input logic [7:0] m1,
                        input int nbytes, input string req);
    cs_begin();
    send_bits({opc, a}, 8);
    for (int b = 0; b < nbytes; b++) begin
      logic [7:0] m;
      m = (b == 0) ? m0 : m1;
      send_bits(m, 8);
      if (!protect_mask[a]) begin
        if (opc == SET)      model[a] = model[a] | m;
        else if (opc == CLR) model[a] = model[a] & ~m;
      end
      expect_reg(a, req);
      drain();
    end
    cs_end();
  endtask

  // Monitor: pops expected items and compares against the read port
  initial begin
    forever begin
      item_t it;
      @(negedge clk);
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        rd_addr = it.addr;
        #1;
        n_chk++;
        if (rd_data !== it.exp) begin
          n_fail++;
          $display("FAIL %s: reg %0d actual %02h expected %02h", it.req, it.addr, rd_data, it.exp);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: reset state
    expect_reg(5'd0, "R1");
    expect_reg(5'd5, "R1");
    expect_reg(5'd31, "R1");
    drain();

    // R3, R5: set on register 3
    bitmod(SET, 5'd3, 8'hF1, 8'h00, 1, "R3");
    // R4: F1h cleared with 17h gives E0h
    bitmod(CLR, 5'd3, 8'h17, 8'h00, 1, "R4");

    // R9: two set bytes then a clear in further transactions
    bitmod(SET, 5'd10, 8'hA5, 8'h0F, 2, "R9");
    bitmod(CLR, 5'd10, 8'h3C, 8'h01, 2, "R9");

    // R2: index order, 10000b must hit register 16 and not register 1
    bitmod(SET, 5'd16, 8'h5A, 8'h00, 1, "R2");
    expect_reg(5'd1, "R2");
    drain();

    // R6: byte cut short by chip-select is dropped
    cs_begin();
    send_bits({SET, 5'd3}, 8);
    send_bits(8'hFF, 5);
    cs_end();
    expect_reg(5'd3, "R6");
    drain();
    // R6: a full byte followed by a partial one keeps only the full byte
    cs_begin();
    send_bits({SET, 5'd10}, 8);
    send_bits(8'h10, 8);
    model[10] = model[10] | 8'h10;
    send_bits(8'hFF, 7);
    cs_end();
    expect_reg(5'd10, "R6");
    drain();

    // R7: protected registers stay unchanged
    bitmod(SET, 5'd31, 8'hFF, 8'h00, 1, "R7");
    bitmod(SET, 5'd0, 8'h81, 8'h00, 1, "R7");

    // R8: unknown codes leave everything alone
    cs_begin();
    send_bits({3'b011, 5'd3}, 8);
    send_bits(8'hFF, 8);
    send_bits(8'h00, 8);
    expect_reg(5'd3, "R8");
    drain();
    cs_end();
    cs_begin();
    send_bits({3'b110, 5'd10}, 8);
    send_bits(8'hFF, 8);
    cs_end();
    expect_reg(5'd10, "R8");
    drain();
    // R8: next transaction decoded normally
    bitmod(CLR, 5'd3, 8'hC0, 8'h00, 1, "R8");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule